// File: doc/BRIEF.md
# Serial Gain-Control Register Slave

This block is the control-side slave for a single 8-bit gain setting in a gain-stage front end. A host reaches it over a three-wire serial link: an active-low chip select, a serial clock and one half-duplex data line. The data line is split here into an input, an output and an output-enable, so the pad driver sits outside the block. Every transaction is a 24-bit frame. The first bit is a direction flag, the next fifteen bits are an address, and the last eight bits are a data byte. All bits travel most significant bit first.

A write to the gain register replaces its contents, but only once the final frame bit has arrived. A read turns the data line around after the address and returns the stored byte. The register drives two outputs continuously. The upper two bits select the size of the fast-attenuation step: 00 gives the smallest step and 11 the largest, doubling at each code. The lower six bits form the gain code, where 0 is the highest gain.

The link signals are sampled by a system clock that runs much faster than the serial clock. The serial clock, chip select and data line pass through a two-stage synchronizer, and edges are found inside the system clock domain.

Top module: `spi_gain_slave`

## Requirements
- R1: After synchronous reset the register holds 0x00, so `fa_step` = 0 and `gain_code` = 0, and `sdio_oe` is low.
- R2: A complete 24-bit frame whose first bit is 0 (write) and whose 15-bit address is 0x100 loads the last 8 frame bits into the register. Bits 7:6 appear on `fa_step` and bits 5:0 appear on `gain_code`.
- R3: In a frame whose first bit is 1 (read) with address 0x100, the block drives the stored byte MSB first on `sdio_out`. It drives one bit per falling serial-clock edge, starting at the falling edge after the 16th rising edge. `sdio_oe` is high only while these eight bits are being driven, and the read leaves the register unchanged.
- R4: A write frame with any address other than 0x100, compared over all 15 address bits, leaves the register unchanged.
- R5: A read frame with any address other than 0x100 returns 0x00 on `sdio_out`.
- R6: If chip select rises before the 24th rising edge, the frame is dropped with no register change. The next frame is decoded from its first bit.
- R7: The register changes only in the cycle after the 24th bit of a write frame is taken in. During a frame the outputs keep their previous value.
- R8: While chip select is inactive, `sdio_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial link |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| sdio_in | input | 1 | Data line as seen from the pad |
| sdio_out | output | 1 | Read data driven toward the pad |
| sdio_oe | output | 1 | High when the block drives the data line |
| fa_step | output | 2 | Fast-attenuation step select, register bits 7:6 |
| gain_code | output | 6 | Gain code, register bits 5:0 |

## Verification
The assertions assume that each serial-clock phase and each chip-select transition lasts several system clocks. Under that condition every link edge is seen once, after the synchronizer and in order, and a commit is always followed by a register update. They also assume that chip select returns high between frames. The stimulus holds every serial-clock half period for eight system clocks and keeps chip select stable for a half period around each frame. Frames are separated by an idle gap, so the synchronized edges never merge or reorder.

// File: rtl/spi_gain_pkg.sv
package spi_gain_pkg;

    localparam int ADDR_W     = 15;
    localparam int DATA_W     = 8;
    localparam int HDR_BITS   = 1 + ADDR_W;
    localparam int FRAME_BITS = HDR_BITS + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam int SYNC_DEPTH = 2;

    localparam logic [ADDR_W-1:0] GAIN_ADDR = 15'h100;

    typedef struct packed {
        logic [1:0] fa_step;
        logic [5:0] gain;
    } gain_reg_t;

    localparam gain_reg_t GAIN_RESET = '0;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
    } hdr_t;

    typedef struct packed {
        hdr_t              hdr;
        logic [DATA_W-1:0] data;
    } frame_t;

    function automatic logic hits_gain(input logic [ADDR_W-1:0] a);
        return a == GAIN_ADDR;
    endfunction

    function automatic gain_reg_t to_gain(input logic [DATA_W-1:0] b);
        return gain_reg_t'(b);
    endfunction

endpackage

// File: rtl/spi_gain_sync.sv
module spi_gain_sync #(
    parameter int               WIDTH     = 3,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    logic [STAGES-1:0][WIDTH-1:0] chain;
    logic [WIDTH-1:0]             prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= RESET_VAL;
            prev <= RESET_VAL;
        end else begin
            chain[0] <= async_i;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
            prev <= chain[STAGES-1];
        end
    end

    assign sync_o = chain[STAGES-1];
    assign rise_o = chain[STAGES-1] & ~prev;
    assign fall_o = ~chain[STAGES-1] & prev;

endmodule

// File: rtl/spi_gain_frame.sv
module spi_gain_frame
    import spi_gain_pkg::*;
#(
    parameter int FRAME_LEN = FRAME_BITS,
    parameter int HDR_LEN   = HDR_BITS,
    parameter int BYTE_W    = DATA_W
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_act,
    input  logic      sclk_rise,
    input  logic      sclk_fall,
    input  logic      sdi,
    input  gain_reg_t reg_value,
    output logic      commit,
    output gain_reg_t wdata,
    output logic      rd_mode,
    output logic      sdo,
    output logic      sdo_oe
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] HDR_IDX  = CNT_W'(HDR_LEN - 1);
    localparam logic [CNT_W-1:0] DATA_LO  = CNT_W'(HDR_LEN);
    localparam logic [CNT_W-1:0] END_CNT  = CNT_W'(FRAME_LEN);

    logic [CNT_W-1:0]     cnt;
    logic [FRAME_LEN-2:0] shreg;
    logic [BYTE_W-1:0]    rd_buf;
    hdr_t                 hdr_now;
    frame_t               frame_now;

    // header and full frame as they stand once the current bit is added
    assign hdr_now   = hdr_t'({shreg[HDR_LEN-2:0], sdi});
    assign frame_now = frame_t'({shreg, sdi});

    assign commit = cs_act && sclk_rise && (cnt == LAST_IDX)
                    && !frame_now.hdr.rd && hits_gain(frame_now.hdr.addr);
    assign wdata  = to_gain(frame_now.data);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            shreg   <= '0;
            rd_buf  <= '0;
            rd_mode <= 1'b0;
            sdo     <= 1'b0;
            sdo_oe  <= 1'b0;
        end else if (!cs_act) begin
            cnt     <= '0;
            rd_buf  <= '0;
            rd_mode <= 1'b0;
            sdo_oe  <= 1'b0;
        end else begin
            if (sclk_rise && cnt < END_CNT) begin
                shreg <= {shreg[FRAME_LEN-3:0], sdi};
                cnt   <= cnt + 1'b1;
                if (cnt == HDR_IDX) begin
                    rd_mode <= hdr_now.rd;
                    rd_buf  <= hits_gain(hdr_now.addr) ? BYTE_W'(reg_value) : '0;
                end
            end
            if (sclk_fall && rd_mode) begin
                if (cnt >= DATA_LO && cnt < END_CNT) begin
                    sdo_oe <= 1'b1;
                    sdo    <= rd_buf[BYTE_W-1];
                    rd_buf <= {rd_buf[BYTE_W-2:0], 1'b0};
                end else if (cnt == END_CNT) begin
                    sdo_oe <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/spi_gain_regfile.sv
module spi_gain_regfile
    import spi_gain_pkg::*;
#(
    parameter gain_reg_t RESET_VALUE = GAIN_RESET
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      commit,
    input  gain_reg_t wdata,
    output gain_reg_t reg_q
);

    always_ff @(posedge clk) begin
        if (rst)         reg_q <= RESET_VALUE;
        else if (commit) reg_q <= wdata;
    end

endmodule

// File: rtl/spi_gain_slave.sv
module spi_gain_slave
    import spi_gain_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_DEPTH
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sclk,
    input  logic       cs_n,
    input  logic       sdio_in,
    output logic       sdio_out,
    output logic       sdio_oe,
    output logic [1:0] fa_step,
    output logic [5:0] gain_code
);

    localparam int LINK_W = 3;
    localparam int SCLK_B = 0;
    localparam int CSN_B  = 1;
    localparam int SDI_B  = 2;

    logic [LINK_W-1:0] link_raw, link_s, link_rise, link_fall;
    logic              cs_act;
    logic              commit;
    logic              rd_mode;
    gain_reg_t         wdata;
    gain_reg_t         reg_q;

    assign link_raw = {sdio_in, cs_n, sclk};

    spi_gain_sync #(
        .WIDTH     (LINK_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (LINK_W'(1) << CSN_B)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (link_raw),
        .sync_o  (link_s),
        .rise_o  (link_rise),
        .fall_o  (link_fall)
    );

    assign cs_act = ~link_s[CSN_B];

    spi_gain_frame u_frame (
        .clk       (clk),
        .rst       (rst),
        .cs_act    (cs_act),
        .sclk_rise (link_rise[SCLK_B]),
        .sclk_fall (link_fall[SCLK_B]),
        .sdi       (link_s[SDI_B]),
        .reg_value (reg_q),
        .commit    (commit),
        .wdata     (wdata),
        .rd_mode   (rd_mode),
        .sdo       (sdio_out),
        .sdo_oe    (sdio_oe)
    );

    spi_gain_regfile u_reg (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .wdata  (wdata),
        .reg_q  (reg_q)
    );

    assign fa_step   = reg_q.fa_step;
    assign gain_code = reg_q.gain;

endmodule

// File: rtl/spi_gain_slave_chk.sv
module spi_gain_slave_chk
    import spi_gain_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      cs_act,
    input logic      commit,
    input gain_reg_t wdata,
    input gain_reg_t reg_q,
    input logic      rd_mode,
    input logic      sdio_oe
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (reg_q == GAIN_RESET && !sdio_oe));

    // R2
    commit_load_chk: assert property (@(posedge clk) disable iff (rst)
        commit |=> (reg_q == $past(wdata)));

    // R7
    no_partial_update_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(reg_q) |-> $past(commit));

    // R3
    drive_only_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        sdio_oe |-> rd_mode);

    // R8
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> !sdio_oe);

endmodule

bind spi_gain_slave spi_gain_slave_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .cs_act  (cs_act),
    .commit  (commit),
    .wdata   (wdata),
    .reg_q   (reg_q),
    .rd_mode (rd_mode),
    .sdio_oe (sdio_oe)
);

// File: tb/spi_gain_slave_test.sv
module spi_gain_slave_test;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       sdio_in = 1'b0;
    logic       sdio_out;
    logic       sdio_oe;
    logic [1:0] fa_step;
    logic [5:0] gain_code;

    int         nchecks = 0;
    int         nfail = 0;
    logic [7:0] model_reg = 8'h00;
    logic [7:0] rd_cap = 8'h00;

    typedef struct {
        string      req;
        bit         is_rd;
        logic [7:0] exp_reg;
        logic [7:0] exp_rd;
    } sb_t;

    sb_t  sb_q[$];
    event frame_end;

    always #10 clk = ~clk;

    spi_gain_slave uut (
        .clk       (clk),
        .rst       (rst),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sdio_in   (sdio_in),
        .sdio_out  (sdio_out),
        .sdio_oe   (sdio_oe),
        .fa_step   (fa_step),
        .gain_code (gain_code)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        nchecks++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: clocks one frame (nbits < 24 aborts it) and queues the expected result
    task automatic send_frame(input bit rd, input logic [14:0] addr, input logic [7:0] din,
                              input int nbits, input string req);
        logic [23:0] f;
        sb_t         it;
        f = {rd, addr, din};
        it.req    = req;
        it.is_rd  = rd && (nbits == 24);
        it.exp_rd = (addr == 15'h100) ? model_reg : 8'h00;
        rd_cap    = 8'h00;
        cs_n = 1'b0;
        idle(HALF);
        for (int i = 0; i < nbits; i++) begin
            sdio_in = (rd && i >= 16) ? 1'b1 : f[23-i];
            idle(HALF);
            if (rd && i >= 16) begin
                check({req, " R3 oe during data"}, {7'b0, sdio_oe}, 8'h01);
                rd_cap[23-i] = sdio_out;
            end
            if (i == 15)
                check({req, " R3 oe in header"}, {7'b0, sdio_oe}, 8'h00);
            if (!rd && i == 23)
                check({req, " R7 before last bit"}, {fa_step, gain_code}, model_reg);
            sclk = 1'b1;
            idle(HALF);
            sclk = 1'b0;
        end
        idle(HALF);
        cs_n = 1'b1;
        sdio_in = 1'b0;
        if (nbits == 24 && !rd && addr == 15'h100) model_reg = din;
        it.exp_reg = model_reg;
        sb_q.push_back(it);
        -> frame_end;
        idle(16);
    endtask

    // monitor: compares design results against queued expectations
    initial begin
        forever begin
            sb_t it;
            @(frame_end);
            idle(8);
            it = sb_q.pop_front();
            check({it.req, " register"}, {fa_step, gain_code}, it.exp_reg);
            check({it.req, " R8 oe idle"}, {7'b0, sdio_oe}, 8'h00);
            if (it.is_rd) check({it.req, " read data"}, rd_cap, it.exp_rd);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchecks, nfail);
        $finish;
    end

    initial begin
        idle(5);
        rst = 1'b0;
        idle(4);
        check("R1 reset register", {fa_step, gain_code}, 8'h00);
        check("R1 reset oe", {7'b0, sdio_oe}, 8'h00);

        send_frame(1'b0, 15'h100, 8'hA5, 24, "R2 write A5");
        send_frame(1'b1, 15'h100, 8'h00, 24, "R3 read A5");
        send_frame(1'b0, 15'h200, 8'h3C, 24, "R4 other addr");
        send_frame(1'b0, 15'h4100, 8'h3C, 24, "R4 high addr bit");
        send_frame(1'b0, 15'h101, 8'h11, 24, "R4 neighbour addr");
        send_frame(1'b1, 15'h0FF, 8'h00, 24, "R5 read 0FF");
        send_frame(1'b1, 15'h101, 8'h00, 24, "R5 read 101");
        send_frame(1'b0, 15'h100, 8'h11, 10, "R6 abort at 10");
        send_frame(1'b0, 15'h100, 8'h11, 23, "R6 abort at 23");
        send_frame(1'b0, 15'h100, 8'h7E, 24, "R6 frame after abort");
        send_frame(1'b1, 15'h100, 8'h00, 24, "R3 read 7E");
        send_frame(1'b0, 15'h100, 8'hC0, 24, "R2 write C0");
        send_frame(1'b0, 15'h100, 8'hFF, 24, "R2 write FF");
        send_frame(1'b1, 15'h100, 8'h00, 24, "R3 read FF");
        send_frame(1'b0, 15'h100, 8'h00, 24, "R2 write 00");
        send_frame(1'b1, 15'h100, 8'h00, 24, "R3 read 00");
        send_frame(1'b1, 15'h100, 8'h00, 12, "R6 read abort");
        send_frame(1'b0, 15'h100, 8'h5A, 24, "R7 write 5A");

        idle(20);
        $display("== %0d vectors applied, %0d miscompares ==", nchecks, nfail);
        $finish;
    end

endmodule